// File: doc/BRIEF.md
# Timer Output Compare Unit

This block pairs a 16-bit up-counter with two compare channels, A and B. The counter advances once per clock while the tick enable is high. Each channel holds a compare value that software writes. While a tick is present, each channel compares its value with the count. On equality the channel sends a one-cycle match strobe to the waveform stage. At the next clock edge the channel sets its match flag and applies its pin action. A flag whose interrupt enable is set drives an interrupt request. The flag clears when the interrupt controller acknowledges it, or when software writes a one to it.

Channel A can also set the counter's period. With the period-select bit set, the count wraps to zero after it equals compare A. With the bit clear, the count runs over the whole 16-bit range. Two indications mark the extreme values: one when the count equals the active TOP, and one when the count is zero.

Software uses a single write port. A 2-bit select picks one of four targets: compare A, compare B, the control word, or the flag-clear word.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the count, both compare values, the control word, both flags, both interrupt requests and both pins are zero. TOP is all ones, so the count is zero and the bottom indication is high.
- R2: On each clock with `tick_en` high, the count rises by one. When the count equals TOP, it returns to zero instead. With the default TOP, 0xFFFF is followed by 0.
- R3: `match_o[i]` is high in any cycle where `tick_en` is high and the count equals compare i. Flag i becomes 1 at the next clock edge, not in the cycle of equality.
- R4: `irq_o[i]` is high exactly while flag i is 1 and control bit i (interrupt enable for channel i) is 1.
- R5: A one-cycle pulse on `int_ack[i]` clears flag i.
- R6: A write with `wr_sel`=3 clears flag i for each data bit i that is 1. Data bits that are 0 leave their flag unchanged.
- R7: If a match sets a flag in the same cycle that an acknowledge or a write-one clear targets that flag, the flag ends at 1.
- R8: Control bit 6 set makes compare A the TOP value. The count then runs 0..A and wraps, `at_top_o` is high while the count equals TOP, and `at_bottom_o` is high while the count is zero.
- R9: The pin action on a match is chosen by control bits 3:2 for A and 5:4 for B. Code 00 drives the pin low from the next edge on, 01 toggles it, 10 clears it and 11 sets it.
- R10: While `tick_en` is low the count holds, and no flag is set and no pin changes.
- R11: `wr_sel` 0 and 1 write compare A and B. `wr_sel` 2 writes the control word from data bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer tick qualifier |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 cmp A, 1 cmp B, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| int_ack | input | 2 | Interrupt acknowledge per channel |
| cnt_o | output | 16 | Current count |
| match_o | output | 2 | Match strobes to the waveform stage |
| flag_o | output | 2 | Match flags |
| irq_o | output | 2 | Interrupt requests |
| pin_o | output | 2 | Waveform pins |
| at_top_o | output | 1 | Count equals active TOP |
| at_bottom_o | output | 1 | Count is zero |

## Verification
The comparison is first driven with a steady tick run into a single compare value. This separates the cycle of the strobe from the cycle of the flag and exposes an off-by-one in either. A frozen tick with the count parked on the compare value shows whether the comparison is wrongly left unqualified. Coincident set and clear stimuli show which side wins. A short period set by compare A, with both channels active in different pin modes, tells toggle, set, clear and disconnect apart and checks the wrap point. A full 65536-step run confirms the default TOP.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_CLEAR  = 2'b10,
        PIN_SET    = 2'b11
    } pin_act_e;

endpackage

// File: rtl/tmr_cmp_counter.sv
module tmr_cmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_top_o,
    output logic             at_bottom_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (st_q.cnt == top_i) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign at_top_o    = (st_q.cnt == top_i);
    assign at_bottom_o = (st_q.cnt == '0);

    // R10: no tick, no movement
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.cnt));

    // R2: single step below TOP
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.cnt != top_i) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R8: wrap to zero at TOP
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.cnt == top_i) |=> (st_q.cnt == '0));

endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic             ie_i,
    input  logic [1:0]       act_i,
    input  logic             clr_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             match_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             pin_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             pin;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        hit;
    pin_act_e    act;

    assign act = pin_act_e'(act_i);
    assign hit = tick_i && (cnt_i == st_q.cmp);

    always_comb begin
        st_d = st_q;

        if (cmp_we_i) begin
            st_d.cmp = cmp_wdata_i;
        end

        // clears first, hardware set last so it takes priority
        if (clr_i || ack_i) begin
            st_d.flag = 1'b0;
        end
        if (hit) begin
            st_d.flag = 1'b1;
        end

        case (act)
            PIN_OFF:    st_d.pin = 1'b0;
            PIN_TOGGLE: if (hit) st_d.pin = ~st_q.pin;
            PIN_CLEAR:  if (hit) st_d.pin = 1'b0;
            PIN_SET:    if (hit) st_d.pin = 1'b1;
            default:    st_d.pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o   = st_q.cmp;
    assign match_o = hit;
    assign flag_o  = st_q.flag;
    assign irq_o   = st_q.flag & ie_i;
    assign pin_o   = st_q.pin;

    // R3, R7: a match always leaves the flag set
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.flag);

    // R5: acknowledge without a match clears
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit) |=> !st_q.flag);

    // R6: write-one clear without a match clears
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !st_q.flag);

    // R10: no tick, no new flag
    p_no_tick_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !st_q.flag) |=> !st_q.flag);

    // R10: no tick, pin holds unless disconnected
    p_no_tick_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && act_i != 2'b00) |=> $stable(st_q.pin));

    // R9: disconnected mode holds the pin low
    p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == 2'b00) |=> !st_q.pin);

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_en,
    input  logic                              wr_en,
    input  logic [$clog2(NUM_CH+2)-1:0]       wr_sel,
    input  logic [CNT_W-1:0]                  wr_data,
    input  logic [NUM_CH-1:0]                 int_ack,
    output logic [CNT_W-1:0]                  cnt_o,
    output logic [NUM_CH-1:0]                 match_o,
    output logic [NUM_CH-1:0]                 flag_o,
    output logic [NUM_CH-1:0]                 irq_o,
    output logic [NUM_CH-1:0]                 pin_o,
    output logic                              at_top_o,
    output logic                              at_bottom_o
);

    localparam int SEL_W      = $clog2(NUM_CH + 2);
    localparam int SEL_CTL    = NUM_CH;
    localparam int SEL_CLR    = NUM_CH + 1;
    localparam int CTL_W      = 3 * NUM_CH + 1;
    localparam int TOPSEL_BIT = 3 * NUM_CH;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } unit_state_t;

    unit_state_t       st_d, st_q;
    logic [NUM_CH-1:0] clr_vec;
    logic [CNT_W-1:0]  cmp_arr [NUM_CH];
    logic [CNT_W-1:0]  top_val;
    logic [CNT_W-1:0]  cnt;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_sel == SEL_W'(SEL_CTL)) begin
            st_d.ctl = wr_data[CTL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_vec = (wr_en && wr_sel == SEL_W'(SEL_CLR)) ? wr_data[NUM_CH-1:0] : '0;
    assign top_val = st_q.ctl[TOPSEL_BIT] ? cmp_arr[0] : '1;

    tmr_cmp_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_en),
        .top_i       (top_val),
        .cnt_o       (cnt),
        .at_top_o    (at_top_o),
        .at_bottom_o (at_bottom_o)
    );

    assign cnt_o = cnt;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic cmp_we;
        assign cmp_we = wr_en && (wr_sel == SEL_W'(g));

        tmr_cmp_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_en),
            .cnt_i       (cnt),
            .cmp_we_i    (cmp_we),
            .cmp_wdata_i (wr_data),
            .ie_i        (st_q.ctl[g]),
            .act_i       (st_q.ctl[NUM_CH + 2*g +: 2]),
            .clr_i       (clr_vec[g]),
            .ack_i       (int_ack[g]),
            .cmp_o       (cmp_arr[g]),
            .match_o     (match_o[g]),
            .flag_o      (flag_o[g]),
            .irq_o       (irq_o[g]),
            .pin_o       (pin_o[g])
        );
    end

    // R11: a control write lands in the next cycle
    p_ctl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(SEL_CTL)) |=> (st_q.ctl == $past(wr_data[CTL_W-1:0])));

    // R4: interrupt never without its flag
    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~flag_o) == '0));

endmodule

// File: tb/tmr_cmp_unit_tb_top.sv
module tmr_cmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  int_ack = '0;
    logic [15:0] cnt_o;
    logic [1:0]  match_o, flag_o, irq_o, pin_o;
    logic        at_top_o, at_bottom_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tmr_cmp_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .int_ack     (int_ack),
        .cnt_o       (cnt_o),
        .match_o     (match_o),
        .flag_o      (flag_o),
        .irq_o       (irq_o),
        .pin_o       (pin_o),
        .at_top_o    (at_top_o),
        .at_bottom_o (at_bottom_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; int_ack = '0;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 cnt", cnt_o, 0);
        chk("R1 flags", flag_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 pins", pin_o, 0);
        chk("R1 bottom", at_bottom_o, 1);
        chk("R1 top", at_top_o, 0);
    endtask

    task automatic t_match_timing();
        do_write(2'd0, 16'd100);          // R11 cmp A
        do_write(2'd1, 16'd3);            // R11 cmp B
        tick_en = 1'b1;
        wait_n(3);
        chk("R2 count after 3 ticks", cnt_o, 3);
        chk("R3 strobe on equality", match_o[1], 1);
        chk("R3 flag not yet set", flag_o[1], 0);
        wait_n(1);
        chk("R3 flag next edge", flag_o[1], 1);
        chk("R3 strobe gone", match_o[1], 0);
        chk("R4 irq off while disabled", irq_o[1], 0);
        tick_en = 1'b0;                   // count frozen at 4
    endtask

    task automatic t_irq_ack();
        do_write(2'd2, 16'h0002);         // R11 enable irq B
        chk("R4 irq with enable", irq_o, 2'b10);
        int_ack = 2'b10;
        @(negedge clk);
        int_ack = 2'b00;
        chk("R5 ack clears flag", flag_o[1], 0);
        chk("R5 irq drops", irq_o[1], 0);
    endtask

    task automatic t_w1c();
        do_write(2'd1, 16'd4);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;                   // count 5
        chk("R3 flag B set again", flag_o[1], 1);
        do_write(2'd3, 16'h0000);
        chk("R6 zero write no effect", flag_o[1], 1);
        do_write(2'd3, 16'h0001);
        chk("R6 other bit no effect", flag_o[1], 1);
        do_write(2'd3, 16'h0002);
        chk("R6 one clears", flag_o[1], 0);
    endtask

    task automatic t_collision();
        do_write(2'd1, 16'd5);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h0002; int_ack = 2'b10;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; int_ack = 2'b00;
        chk("R7 set wins", flag_o[1], 1);
        chk("R2 count 6", cnt_o, 6);
    endtask

    task automatic t_gate();
        do_write(2'd1, 16'd6);
        do_write(2'd3, 16'h0002);
        wait_n(5);
        chk("R10 count holds", cnt_o, 6);
        chk("R10 no strobe", match_o[1], 0);
        chk("R10 no flag", flag_o[1], 0);
    endtask

    task automatic t_top();
        do_reset();
        do_write(2'd0, 16'd4);
        do_write(2'd2, 16'h0040);
        tick_en = 1'b1;
        wait_n(4);
        chk("R8 reaches TOP", cnt_o, 4);
        chk("R8 top flag", at_top_o, 1);
        wait_n(1);
        chk("R8 wraps", cnt_o, 0);
        chk("R8 bottom flag", at_bottom_o, 1);
        chk("R3 flag A at TOP", flag_o[0], 1);
        wait_n(1);
        chk("R8 restarts", cnt_o, 1);
        tick_en = 1'b0;
    endtask

    task automatic t_pins();
        do_reset();
        do_write(2'd0, 16'd4);
        do_write(2'd1, 16'd2);
        do_write(2'd2, 16'h005C);         // top sel, B toggle, A set
        tick_en = 1'b1;
        wait_n(2);
        chk("R9 B before match", pin_o[1], 0);
        wait_n(1);
        chk("R9 B toggled high", pin_o[1], 1);
        chk("R9 A still low", pin_o[0], 0);
        wait_n(2);
        chk("R9 A set", pin_o[0], 1);
        wait_n(3);
        chk("R9 B toggled low", pin_o[1], 0);
        tick_en = 1'b0;                   // count 3
        do_write(2'd2, 16'h0060);         // A off, B clear
        @(negedge clk);
        chk("R9 off forces low", pin_o[0], 0);
        do_write(2'd2, 16'h0070);         // B set
        tick_en = 1'b1;
        wait_n(4);
        chk("R9 B low before match", pin_o[1], 0);
        wait_n(1);
        chk("R9 B set", pin_o[1], 1);
        tick_en = 1'b0;                   // count 3
        do_write(2'd2, 16'h0060);         // B clear
        tick_en = 1'b1;
        wait_n(4);
        chk("R9 B held before match", pin_o[1], 1);
        wait_n(1);
        chk("R9 B cleared", pin_o[1], 0);
        tick_en = 1'b0;
    endtask

    task automatic t_wrap();
        do_reset();
        tick_en = 1'b1;
        wait_n(65535);
        chk("R2 full count", cnt_o, 16'hFFFF);
        chk("R1 default TOP", at_top_o, 1);
        wait_n(1);
        chk("R2 rolls over", cnt_o, 0);
        tick_en = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset();
        t_match_timing();
        t_irq_ack();
        t_w1c();
        t_collision();
        t_gate();
        t_top();
        t_pins();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule